// File: doc/BRIEF.md
# Maskable Interrupt Acceptance and Entry Controller

This block sits beside a processor pipeline. It decides which of many maskable interrupt request lines is taken next, and then carries out the processor-side entry steps. Each source has a mask bit and a 3-bit priority level, both written through a small configuration port. A rising edge on a request line sets a pending flag for that source. Among the unmasked pending sources, the arbiter picks the one with the numerically lowest level. When two sources share a level, the lowest source index wins.

A winner is taken only if all of the following hold:
- the processor status word has both its interrupt-disable flag and its NP flag clear;
- the in-service level stack still has room;
- the stack is empty, or the winner's level is strictly more urgent than the level on top of the stack.

Entry runs through a state machine with four states:
- **ST_IDLE** waits for work.
- The **accept** transition (ST_IDLE to ST_SAVE) latches the winner and copies the current PC and status word into the save registers.
- **ST_SAVE** writes the source's exception code into the cause register, then moves to ST_ENTER.
- **ST_ENTER** pulses the acknowledge for one cycle. It drives the handler address and the updated status word with a PC-load strobe, clears that source's pending flag, pushes its level onto the stack, and returns to ST_IDLE.

A return strobe seen in ST_IDLE takes the **return** transition to **ST_RESTORE**. That state drives the saved PC and status word back with the PC-load strobe and pops one level, then goes back to ST_IDLE. The return strobe takes precedence over a pending request in the same cycle.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, ack and pc_load are 0, the save registers and cause_code are 0, every source is masked and every level is 7.
- R2: A rising edge on irq_req[i] sets source i pending. A masked pending source is kept and taken once unmasked. The flag clears when the source is acknowledged, and a line held high does not request again.
- R3: No source is accepted while cur_psw bit 5 (interrupt disable) or bit 7 (NP) is 1, and the request stays pending.
- R4: On acceptance, save_pc takes cur_pc and save_psw takes cur_psw.
- R5: On acceptance, cause_code (16 bits) becomes CODE_BASE + 16 × source index.
- R6: Entry gives a one-cycle ack with pc_load and ack_src equal to the source. At the same time new_pc is HANDLER_BASE + 16 × index, and new_psw is save_psw with bit 5 set and bit 6 (EP) cleared.
- R7: The lowest level value wins; on equal levels the lowest index wins.
- R8: With a level in service, only a strictly lower level value is accepted; an equal level waits.
- R9: A return strobe gives a one-cycle pc_load with new_pc = save_pc and new_psw = save_psw, and pops one in-service level.
- R10: While STACK_DEPTH levels are in service, no source is accepted.
- R11: A configuration write with cfg_idx ≥ NUM_SRC has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | NUM_SRC | Request lines, rising-edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index of the write |
| cfg_mask | input | 1 | Mask bit to write (1 = masked) |
| cfg_prio | input | PRIO_W | Level to write (0 most urgent) |
| cur_pc | input | PC_W | Current processor PC |
| cur_psw | input | PSW_W | Current processor status word |
| ret_strobe | input | 1 | End-of-service return strobe |
| new_pc | output | PC_W | PC to load when pc_load is 1 |
| new_psw | output | PSW_W | Status word to load when pc_load is 1 |
| pc_load | output | 1 | Load strobe for new_pc and new_psw |
| save_pc | output | PC_W | Interrupt PC save register |
| save_psw | output | PSW_W | Interrupt status save register |
| cause_code | output | 16 | Lower half of the exception cause register |
| ack | output | 1 | Acknowledge pulse |
| ack_src | output | IDX_W | Acknowledged source index |

## Verification
The bench builds the block with NUM_SRC = 12 and STACK_DEPTH = 2. With 12 sources, the 4-bit index can hold the values 12 to 15, which lets the out-of-range configuration write be exercised. With a stack depth of 2, a full in-service stack is reached after only two nested entries. That makes the full-stack blocking case and the ordering of returns against pending requests short, directed sequences.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_ENTER,
        ST_RESTORE
    } irqc_state_e;

    // Status word flag positions
    localparam int PSW_ID_BIT = 5;
    localparam int PSW_EP_BIT = 6;
    localparam int PSW_NP_BIT = 7;

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
    parameter int NUM_SRC = 55,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          req,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic                        cfg_mask,
    input  logic [PRIO_W-1:0]           cfg_prio,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_idx,
    output logic [NUM_SRC-1:0]          eligible,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_flat
);

    localparam logic [PRIO_W-1:0] LOWEST_LEVEL = '1;

    logic [NUM_SRC-1:0] req_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_d <= '0;
        else        req_d <= req;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic              pend_q;
        logic              mask_q;
        logic [PRIO_W-1:0] prio_q;
        logic              rise;
        logic              hit_cfg;
        logic              hit_clr;

        assign rise    = req[i] & ~req_d[i];
        assign hit_cfg = cfg_we && (cfg_idx == IDX_W'(i));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                mask_q <= 1'b1;
                prio_q <= LOWEST_LEVEL;
            end else begin
                pend_q <= (pend_q & ~hit_clr) | rise;
                if (hit_cfg) begin
                    mask_q <= cfg_mask;
                    prio_q <= cfg_prio;
                end
            end
        end

        assign eligible[i] = pend_q & ~mask_q;
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;

        AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_clr && !rise) |=> !pend_q); // R2
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 55,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          eligible,
    input  logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx,
    output logic [PRIO_W-1:0]           win_prio
);

    // Scan from the top index down; "<=" lets a lower index take a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i] &&
                (!win_valid || (prio_flat[i*PRIO_W +: PRIO_W] <= win_prio))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> eligible[win_idx]); // R7

endmodule

// File: rtl/irqc_level_stack.sv
module irqc_level_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic              empty,
    output logic              full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PRIO_W-1:0] slots [DEPTH];
    logic [CNT_W-1:0]  cnt;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign top_prio = empty ? '1 : slots[PTR_W'(cnt - 1'b1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) slots[k] <= '1;
        end else if (push && !full) begin
            slots[PTR_W'(cnt)] <= push_prio;
            cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irqc_pkg::*;
#(
    parameter int              NUM_SRC      = 55,
    parameter int              PRIO_W       = 3,
    parameter int              STACK_DEPTH  = 8,
    parameter int              PC_W         = 32,
    parameter int              PSW_W        = 32,
    parameter int              IDX_W        = $clog2(NUM_SRC),
    parameter logic [31:0]     HANDLER_BASE = 32'h0000_0080,
    parameter logic [15:0]     CODE_BASE    = 16'h0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_req,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_mask,
    input  logic [PRIO_W-1:0]   cfg_prio,
    input  logic [PC_W-1:0]     cur_pc,
    input  logic [PSW_W-1:0]    cur_psw,
    input  logic                ret_strobe,
    output logic [PC_W-1:0]     new_pc,
    output logic [PSW_W-1:0]    new_psw,
    output logic                pc_load,
    output logic [PC_W-1:0]     save_pc,
    output logic [PSW_W-1:0]    save_psw,
    output logic [15:0]         cause_code,
    output logic                ack,
    output logic [IDX_W-1:0]    ack_src
);

    localparam int VEC_SHIFT = 4;

    irqc_state_e state_q, state_d;

    logic [NUM_SRC-1:0]        eligible;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      win_valid;
    logic [IDX_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;
    logic [PRIO_W-1:0]         stk_top;
    logic                      stk_empty;
    logic                      stk_full;
    logic                      stk_push;
    logic                      stk_pop;
    logic                      clr_en;
    logic [IDX_W-1:0]          lat_idx;
    logic [PRIO_W-1:0]         lat_prio;
    logic                      psw_blocks;
    logic                      level_ok;
    logic                      accept;

    irqc_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .cfg_we    (cfg_we && (int'(cfg_idx) < NUM_SRC)),
        .cfg_idx   (cfg_idx),
        .cfg_mask  (cfg_mask),
        .cfg_prio  (cfg_prio),
        .clr_en    (clr_en),
        .clr_idx   (lat_idx),
        .eligible  (eligible),
        .prio_flat (prio_flat)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .eligible  (eligible),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    irqc_level_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .push_prio (lat_prio),
        .pop       (stk_pop),
        .top_prio  (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    // Acceptance gate
    assign psw_blocks = cur_psw[PSW_ID_BIT] | cur_psw[PSW_NP_BIT];
    assign level_ok   = stk_empty || (win_prio < stk_top);
    assign accept     = win_valid && !psw_blocks && !stk_full && level_ok;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_strobe)  state_d = ST_RESTORE;
                else if (accept) state_d = ST_SAVE;
            end
            ST_SAVE:    state_d = ST_ENTER;
            ST_ENTER:   state_d = ST_IDLE;
            ST_RESTORE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Entry datapath: steps one and two at acceptance, step three in ST_SAVE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_idx    <= '0;
            lat_prio   <= '0;
            save_pc    <= '0;
            save_psw   <= '0;
            cause_code <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_SAVE) begin
                lat_idx  <= win_idx;
                lat_prio <= win_prio;
                save_pc  <= cur_pc;
                save_psw <= cur_psw;
            end
            if (state_q == ST_SAVE) begin
                cause_code <= CODE_BASE + (16'(lat_idx) << VEC_SHIFT);
            end
        end
    end

    // Outputs: steps four and five in ST_ENTER, restore in ST_RESTORE
    always_comb begin
        new_pc   = '0;
        new_psw  = '0;
        pc_load  = 1'b0;
        ack      = 1'b0;
        ack_src  = lat_idx;
        clr_en   = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (state_q)
            ST_ENTER: begin
                new_pc              = PC_W'(HANDLER_BASE) + (PC_W'(lat_idx) << VEC_SHIFT);
                new_psw             = save_psw;
                new_psw[PSW_ID_BIT] = 1'b1;
                new_psw[PSW_EP_BIT] = 1'b0;
                pc_load             = 1'b1;
                ack                 = 1'b1;
                clr_en              = 1'b1;
                stk_push            = 1'b1;
            end
            ST_RESTORE: begin
                new_pc  = save_pc;
                new_psw = save_psw;
                pc_load = 1'b1;
                stk_pop = 1'b1;
            end
            default: ;
        endcase
    end

    AST_GATED_BY_PSW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && psw_blocks) |=> (state_q != ST_SAVE)); // R3

    AST_ACK_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (pc_load && int'(ack_src) < NUM_SRC)); // R6

    AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (new_psw[PSW_ID_BIT] && !new_psw[PSW_EP_BIT])); // R6

    AST_STRICT_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER && !stk_empty) |-> (lat_prio < stk_top)); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R6

endmodule

// File: tb/irq_accept_ctrl_test.sv
module irq_accept_ctrl_test;

    localparam int NSRC  = 12;
    localparam int IW    = $clog2(NSRC);
    localparam int DEPTH = 2;
    localparam logic [31:0] HB = 32'h0000_0080;
    localparam logic [15:0] CB = 16'h0080;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic            cfg_mask = 1'b1;
    logic [2:0]      cfg_prio = '0;
    logic [31:0]     cpu_pc = '0;
    logic [31:0]     cpu_psw = '0;
    logic            ret_strobe = 1'b0;
    logic [31:0]     new_pc, new_psw, save_pc, save_psw;
    logic            pc_load, ack;
    logic [15:0]     cause_code;
    logic [IW-1:0]   ack_src;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_accept_ctrl #(.NUM_SRC(NSRC), .STACK_DEPTH(DEPTH),
                      .HANDLER_BASE(HB), .CODE_BASE(CB)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .cfg_prio(cfg_prio),
        .cur_pc(cpu_pc), .cur_psw(cpu_psw), .ret_strobe(ret_strobe),
        .new_pc(new_pc), .new_psw(new_psw), .pc_load(pc_load),
        .save_pc(save_pc), .save_psw(save_psw), .cause_code(cause_code),
        .ack(ack), .ack_src(ack_src)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_req = '0; cfg_we = 1'b0; ret_strobe = 1'b0;
        cpu_pc = '0; cpu_psw = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg(input int idx, input bit m, input int p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_mask = m; cfg_prio = 3'(p);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        irq_req[idx] = 1'b1;
        @(negedge clk);
        irq_req[idx] = 1'b0;
    endtask

    task automatic wait_ack(input int n, output bit got);
        got = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (ack) begin got = 1'b1; break; end
        end
    endtask

    // Expect an entry for src: check ack and entry values, then load the CPU model
    task automatic expect_entry(input int src, input string tag);
        bit got;
        logic [31:0] pc0, psw0, epsw;
        pc0 = cpu_pc; psw0 = cpu_psw;
        wait_ack(20, got);
        chk(got, {tag, " ack seen"}, got, 1);
        if (got) begin
            chk(ack_src == IW'(src), {tag, " R7 ack_src"}, ack_src, src);
            chk(pc_load, {tag, " R6 pc_load"}, pc_load, 1);
            chk(new_pc == HB + 32'(src) * 16, {tag, " R6 new_pc"}, new_pc, HB + 32'(src) * 16);
            epsw = psw0; epsw[5] = 1'b1; epsw[6] = 1'b0;
            chk(new_psw == epsw, {tag, " R6 new_psw"}, new_psw, epsw);
            chk(save_pc == pc0, {tag, " R4 save_pc"}, save_pc, pc0);
            chk(save_psw == psw0, {tag, " R4 save_psw"}, save_psw, psw0);
            chk(cause_code == CB + 16'(src) * 16, {tag, " R5 cause"}, cause_code, CB + 16'(src) * 16);
            cpu_pc = new_pc; cpu_psw = new_psw;
            @(negedge clk);
            chk(!ack, {tag, " R6 single pulse"}, ack, 0);
        end
    endtask

    task automatic expect_none(input int n, input string tag);
        bit got;
        wait_ack(n, got);
        chk(!got, tag, got, 0);
    endtask

    task automatic do_ret(input string tag);
        logic [31:0] epc, epsw;
        epc = save_pc; epsw = save_psw;
        @(negedge clk);
        ret_strobe = 1'b1;
        @(negedge clk);
        ret_strobe = 1'b0;
        chk(pc_load && !ack, {tag, " R9 pc_load"}, pc_load, 1);
        chk(new_pc == epc, {tag, " R9 new_pc"}, new_pc, epc);
        chk(new_psw == epsw, {tag, " R9 new_psw"}, new_psw, epsw);
        cpu_pc = new_pc; cpu_psw = new_psw;
    endtask

    task automatic t_reset();
        do_reset();
        chk(!ack && !pc_load, "R1 strobes idle", {ack, pc_load}, 0);
        chk(save_pc == 0 && save_psw == 0, "R1 save regs", save_pc, 0);
        chk(cause_code == 0, "R1 cause", cause_code, 0);
        @(negedge clk); irq_req = '1;
        @(negedge clk); irq_req = '0;
        expect_none(10, "R1 all sources masked at reset");
    endtask

    task automatic t_basic();
        do_reset();
        cfg(3, 0, 4);
        cpu_pc = 32'h0000_1000; cpu_psw = 32'h0000_0041;
        pulse(3);
        expect_entry(3, "basic");
        do_ret("basic");
        chk(cpu_psw == 32'h41, "R9 EP restored", cpu_psw, 32'h41);
        @(negedge clk); irq_req[3] = 1'b1;
        expect_entry(3, "R2 edge");
        expect_none(10, "R2 held level no repeat");
        irq_req[3] = 1'b0;
        do_ret("basic2");
    endtask

    task automatic t_mask_hold();
        do_reset();
        cfg(2, 1, 0);
        pulse(2);
        expect_none(10, "R2 masked held");
        cfg(2, 0, 0);
        expect_entry(2, "R2 unmask takes");
        do_ret("mask");
    endtask

    task automatic t_disable();
        do_reset();
        cfg(1, 0, 2);
        cpu_psw = 32'h20;
        pulse(1);
        expect_none(10, "R3 ID blocks");
        cpu_psw = 32'h80;
        expect_none(10, "R3 NP blocks");
        cpu_psw = 32'h0;
        expect_entry(1, "R3 released");
        do_ret("disable");
    endtask

    task automatic t_prio();
        do_reset();
        cfg(4, 0, 2); cfg(7, 0, 2); cfg(9, 0, 1);
        cpu_psw = 32'h20;
        @(negedge clk); irq_req[4] = 1; irq_req[7] = 1; irq_req[9] = 1;
        @(negedge clk); irq_req = '0;
        cpu_psw = 32'h0;
        expect_entry(9, "R7 lowest level");
        do_ret("prio1");
        expect_entry(4, "R7 tie lowest index");
        do_ret("prio2");
        expect_entry(7, "R7 last");
        do_ret("prio3");
    endtask

    task automatic t_nest();
        do_reset();
        cfg(5, 0, 3); cfg(6, 0, 3); cfg(8, 0, 2);
        pulse(5);
        expect_entry(5, "nest outer");
        cpu_psw[5] = 1'b0;
        pulse(6);
        expect_none(10, "R8 equal level waits");
        pulse(8);
        expect_entry(8, "R8 higher nests");
        do_ret("nest inner");
        expect_none(10, "R8 still waits after one pop");
        do_ret("nest outer");
        expect_entry(6, "R9 pop releases equal");
        do_ret("nest last");
    endtask

    task automatic t_full();
        do_reset();
        cfg(1, 0, 5); cfg(2, 0, 3); cfg(3, 0, 1);
        pulse(1);
        expect_entry(1, "full a");
        cpu_psw[5] = 1'b0;
        pulse(2);
        expect_entry(2, "full b");
        cpu_psw[5] = 1'b0;
        pulse(3);
        expect_none(10, "R10 full stack blocks");
        do_ret("full pop");
        expect_entry(3, "R10 room again");
        do_ret("full r2");
        do_ret("full r3");
    endtask

    task automatic t_cfg_oob();
        do_reset();
        for (int j = NSRC; j < (1 << IW); j++) cfg(j, 0, 0);
        @(negedge clk); irq_req = '1;
        @(negedge clk); irq_req = '0;
        expect_none(10, "R11 out-of-range write ignored");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mask_hold();
        t_disable();
        t_prio();
        t_nest();
        t_full();
        t_cfg_oob();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule